// File: doc/BRIEF.md
# Thermal Protection Stage Aggregator

This block takes the most recent raw reading from each of four temperature sensors and reduces them to one protection temperature. A small control register picks the reduction: the mean of the four readings, the hottest of the four, or one sensor chosen by index. The reduced value is registered and then compared against three programmable stage limits.

When the protection temperature reaches a stage limit, that stage's flag is latched. Software clears a flag by writing one to its status bit. The third and highest stage also drives a hardware shutdown request, which stays high for as long as its flag is held.

Settings and status are reached through a plain single-cycle write port and a combinational read port.

Top module: `thermprot_stage_agg`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `prot_temp_o` = 0, all stage flags = 0, `shutdown_req_o` = 0, and all registers read back as 0.
- R2: Address 0 is the control register. With strategy field bits 17:16 = 2'b00 (mean), `prot_temp_o` equals floor(sum of the four readings / 4) one cycle after the readings are presented. With all four readings at 0x7FFF, the result is 0x7FFF, with no wrap.
- R3: With strategy code 2'b01 (hottest), `prot_temp_o` equals the largest of the four readings one cycle later.
- R4: With strategy code 2'b10 (pick), `prot_temp_o` equals the reading of the sensor whose index is in control bits 19:18, one cycle later. Sensor i occupies bits [15*i+14 : 15*i] of `sns_temp_i`.
- R5: Strategy code 2'b11 behaves exactly like code 2'b01.
- R6: Stage limits sit at addresses 1, 2 and 3 (stages 1 to 3). Stage k's flag sets one cycle after `prot_temp_o` >= limit k, where that limit is nonzero. The flag then stays set until it is cleared. Flags appear on `stage_flag_o[k-1]`.
- R7: A stage limit of 0 never sets its flag, whatever the temperature.
- R8: Address 4 is the status register, with stage 1, 2 and 3 flags at bits 29, 30 and 31. Writing 1 to one of these bits clears that flag on the next cycle, unless its set condition holds in the same cycle, in which case setting wins. Writing 0 leaves the flag unchanged.
- R9: `shutdown_req_o` equals the stage 3 flag in every cycle.
- R10: Read-back shows the control fields at bits 17:16 and 19:18, each limit in bits 14:0, and the status flags at bits 31:29. All other bits and all unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sns_temp_i | input | 60 | Four packed 15-bit raw sensor readings, sensor 0 in the low bits |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 32 | Register read data (combinational) |
| prot_temp_o | output | 15 | Registered protection temperature |
| stage_flag_o | output | 3 | Latched stage flags, stage 1 in bit 0 |
| shutdown_req_o | output | 1 | Hardware shutdown request (stage 3) |

## Verification
The bench builds the block with its default parameters: four sensors, 15-bit readings and three stages. With these values, four readings at the full-scale value 0x7FFF reach the widest sum the mean path must carry, and all four pick indices and every strategy code can be driven. Directed phases walk the protection temperature across each stage limit: one below, exactly at, and above. They cover clearing a flag while its condition still holds, and a zero limit under high readings. A pseudo-random phase then mixes strategy changes, limit rewrites and status clears against the per-cycle model.

// File: rtl/thermprot_pkg.sv
// Shared types and field positions for the thermal protection aggregator.
package thermprot_pkg;
    // Reduction strategy held in the control register
    typedef enum logic [1:0] {
        STRAT_AVG  = 2'b00,
        STRAT_MAX  = 2'b01,
        STRAT_PICK = 2'b10,
        STRAT_RSVD = 2'b11
    } strat_e;

    localparam int DATA_W         = 32;
    localparam int CTRL_STRAT_LSB = 16;
    localparam int CTRL_SEL_LSB   = 18;
endpackage

// File: rtl/thermprot_regs.sv
// Register file: control, stage limits and status read-back.
// Assumes single-cycle writes. Status bits are cleared by writing ones,
// which is signalled to the stage latches through w1c_mask.
module thermprot_regs
    import thermprot_pkg::*;
#(
    parameter int TW         = 15,
    parameter int NUM_SNS    = 4,
    parameter int NUM_STAGES = 3,
    parameter int AW         = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [AW-1:0]            rd_addr,
    input  logic [NUM_STAGES-1:0]    flags,
    output strat_e                   strat,
    output logic [SEL_W-1:0]         sel,
    output logic [NUM_STAGES*TW-1:0] thr_flat,
    output logic [NUM_STAGES-1:0]    w1c_mask,
    output logic [DATA_W-1:0]        rd_data
);
    localparam int SEL_W     = $clog2(NUM_SNS);
    localparam int STAT_ADDR = NUM_STAGES + 1;
    localparam int STAT_LSB  = DATA_W - NUM_STAGES;

    logic unused_wr_bits;
    assign unused_wr_bits = ^wr_data;

    // Control register and stage limit storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strat    <= STRAT_AVG;
            sel      <= '0;
            thr_flat <= '0;
        end else if (wr_en) begin
            if (wr_addr == '0) begin
                strat <= strat_e'(wr_data[CTRL_STRAT_LSB +: 2]);
                sel   <= wr_data[CTRL_SEL_LSB +: SEL_W];
            end
            for (int k = 0; k < NUM_STAGES; k++) begin
                if (wr_addr == AW'(k + 1))
                    thr_flat[k*TW +: TW] <= wr_data[TW-1:0];
            end
        end
    end

    // Clear strobes for the status bits
    always_comb begin
        w1c_mask = '0;
        if (wr_en && wr_addr == AW'(STAT_ADDR))
            w1c_mask = wr_data[STAT_LSB +: NUM_STAGES];
    end

    // Read-back multiplexer
    always_comb begin
        rd_data = '0;
        if (rd_addr == '0) begin
            rd_data[CTRL_STRAT_LSB +: 2]   = strat;
            rd_data[CTRL_SEL_LSB +: SEL_W] = sel;
        end
        for (int k = 0; k < NUM_STAGES; k++) begin
            if (rd_addr == AW'(k + 1))
                rd_data[TW-1:0] = thr_flat[k*TW +: TW];
        end
        if (rd_addr == AW'(STAT_ADDR))
            rd_data[STAT_LSB +: NUM_STAGES] = flags;
    end
endmodule

// File: rtl/thermprot_reduce.sv
// Combinational reduction of the sensor readings to one temperature.
// Assumes NUM_SNS is a power of two so the mean is a plain shift.
// The reserved strategy code falls back to the hottest reading.
module thermprot_reduce
    import thermprot_pkg::*;
#(
    parameter int TW      = 15,
    parameter int NUM_SNS = 4
) (
    input  logic [NUM_SNS*TW-1:0] sns_flat,
    input  strat_e                strat,
    input  logic [SEL_W-1:0]      sel,
    output logic [TW-1:0]         agg
);
    localparam int SEL_W = $clog2(NUM_SNS);
    localparam int SUM_W = TW + SEL_W;

    logic [TW-1:0]    sns [NUM_SNS];
    logic [SUM_W-1:0] sum;
    logic [TW-1:0]    hottest;

    for (genvar i = 0; i < NUM_SNS; i++) begin : g_unpack
        assign sns[i] = sns_flat[i*TW +: TW];
    end

    // Widened sum and running maximum over all sensors
    always_comb begin
        sum     = '0;
        hottest = '0;
        for (int i = 0; i < NUM_SNS; i++) begin
            sum = sum + SUM_W'(sns[i]);
            if (sns[i] > hottest) hottest = sns[i];
        end
    end

    // Strategy selection
    always_comb begin
        unique case (strat)
            STRAT_AVG:  agg = sum[SUM_W-1 -: TW];
            STRAT_PICK: agg = sns[sel];
            default:    agg = hottest;
        endcase
    end
endmodule

// File: rtl/thermprot_stage.sv
// One protection stage: latches a flag when the temperature reaches a
// nonzero limit, and clears it on a write-one strobe. Setting wins over clearing.
module thermprot_stage #(
    parameter int TW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] temp,
    input  logic [TW-1:0] limit,
    input  logic          clr,
    output logic          flag
);
    logic hit;
    assign hit = (limit != '0) && (temp >= limit);

    // Sticky stage flag
    always_ff @(posedge clk) begin
        if (!rst_n) flag <= 1'b0;
        else        flag <= hit | (flag & ~clr);
    end
endmodule

// File: rtl/thermprot_stage_agg.sv
// Top: reduces four sensor readings, registers the result and drives
// the stage latches. The last stage doubles as the shutdown request.
module thermprot_stage_agg
    import thermprot_pkg::*;
#(
    parameter int TW         = 15,
    parameter int NUM_SNS    = 4,
    parameter int NUM_STAGES = 3,
    parameter int AW         = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_SNS*TW-1:0] sns_temp_i,
    input  logic                  wr_en_i,
    input  logic [AW-1:0]         wr_addr_i,
    input  logic [31:0]           wr_data_i,
    input  logic [AW-1:0]         rd_addr_i,
    output logic [31:0]           rd_data_o,
    output logic [TW-1:0]         prot_temp_o,
    output logic [NUM_STAGES-1:0] stage_flag_o,
    output logic                  shutdown_req_o
);
    localparam int SEL_W = $clog2(NUM_SNS);

    strat_e                   ctrl_strat;
    logic [SEL_W-1:0]         ctrl_sel;
    logic [NUM_STAGES*TW-1:0] thr_flat;
    logic [NUM_STAGES-1:0]    w1c_mask;
    logic [TW-1:0]            agg;

    thermprot_regs #(.TW(TW), .NUM_SNS(NUM_SNS), .NUM_STAGES(NUM_STAGES), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en_i), .wr_addr(wr_addr_i), .wr_data(wr_data_i),
        .rd_addr(rd_addr_i), .flags(stage_flag_o),
        .strat(ctrl_strat), .sel(ctrl_sel), .thr_flat(thr_flat),
        .w1c_mask(w1c_mask), .rd_data(rd_data_o)
    );

    thermprot_reduce #(.TW(TW), .NUM_SNS(NUM_SNS)) u_reduce (
        .sns_flat(sns_temp_i), .strat(ctrl_strat), .sel(ctrl_sel), .agg(agg)
    );

    // Register the protection temperature
    always_ff @(posedge clk) begin
        if (!rst_n) prot_temp_o <= '0;
        else        prot_temp_o <= agg;
    end

    for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
        thermprot_stage #(.TW(TW)) u_stage (
            .clk(clk), .rst_n(rst_n), .temp(prot_temp_o),
            .limit(thr_flat[k*TW +: TW]), .clr(w1c_mask[k]),
            .flag(stage_flag_o[k])
        );
    end

    assign shutdown_req_o = stage_flag_o[NUM_STAGES-1];
endmodule

// File: rtl/thermprot_chk.sv
// Property checker for the aggregator, attached through bind.
module thermprot_chk
    import thermprot_pkg::*;
#(
    parameter int TW         = 15,
    parameter int NUM_SNS    = 4,
    parameter int NUM_STAGES = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input strat_e                   strat,
    input logic [NUM_SNS*TW-1:0]    sns_flat,
    input logic [TW-1:0]            prot,
    input logic [NUM_STAGES-1:0]    flags,
    input logic                     shutdown,
    input logic [NUM_STAGES*TW-1:0] thr_flat,
    input logic [NUM_STAGES-1:0]    w1c
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (prot == '0 && flags == '0 && !shutdown)); // R1

    AST_SHUTDOWN_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown == flags[NUM_STAGES-1]); // R9

    for (genvar i = 0; i < NUM_SNS; i++) begin : g_sns
        AST_HOTTEST_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
            (strat == STRAT_MAX || strat == STRAT_RSVD) |=> prot >= $past(sns_flat[i*TW +: TW])); // R3
    end

    for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stg
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[k] && !w1c[k]) |=> flags[k]); // R6
        AST_ZERO_LIMIT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            (thr_flat[k*TW +: TW] == '0 && (!flags[k] || w1c[k])) |=> !flags[k]); // R7
        AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            (w1c[k] && prot < thr_flat[k*TW +: TW]) |=> !flags[k]); // R8
    end
endmodule

bind thermprot_stage_agg thermprot_chk #(.TW(TW), .NUM_SNS(NUM_SNS), .NUM_STAGES(NUM_STAGES)) u_chk (
    .clk(clk), .rst_n(rst_n), .strat(ctrl_strat), .sns_flat(sns_temp_i),
    .prot(prot_temp_o), .flags(stage_flag_o), .shutdown(shutdown_req_o),
    .thr_flat(thr_flat), .w1c(w1c_mask)
);

// File: tb/tb_thermprot_stage_agg.sv
module tb_thermprot_stage_agg;
    localparam int TW = 15;
    localparam int NS = 4;
    localparam int NG = 3;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] s [NS];
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [31:0]   rd_data;
    logic [TW-1:0] prot;
    logic [NG-1:0] flags;
    logic          sdn;
    logic [NS*TW-1:0] sns_flat;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    // behavioural reference state
    int m_strat, m_sel, m_prot;
    int m_thr [NG];
    int m_stat [NG];

    assign sns_flat = {s[3], s[2], s[1], s[0]};

    always #10 clk = ~clk;

    thermprot_stage_agg dut (
        .clk(clk), .rst_n(rst_n), .sns_temp_i(sns_flat),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .prot_temp_o(prot), .stage_flag_o(flags), .shutdown_req_o(sdn)
    );

    function automatic int ref_agg();
        int sum = 0, mx = 0;
        for (int i = 0; i < NS; i++) begin
            sum += int'(s[i]);
            if (int'(s[i]) > mx) mx = int'(s[i]);
        end
        if (m_strat == 0) return sum / 4;
        if (m_strat == 2) return int'(s[m_sel]);
        return mx;
    endfunction

    function automatic logic [31:0] ref_rd();
        logic [31:0] v = '0;
        if (rd_addr == 0) v = 32'((m_strat << 16) | (m_sel << 18));
        else if (rd_addr >= 1 && rd_addr <= 3) v = 32'(m_thr[rd_addr-1]);
        else if (rd_addr == 4)
            for (int k = 0; k < NG; k++) v[29+k] = m_stat[k][0];
        return v;
    endfunction

    task automatic model_edge();
        int np;
        if (!rst_n) begin
            m_strat = 0; m_sel = 0; m_prot = 0;
            for (int k = 0; k < NG; k++) begin m_thr[k] = 0; m_stat[k] = 0; end
        end else begin
            np = ref_agg();
            for (int k = 0; k < NG; k++) begin
                bit hit, clr;
                hit = (m_thr[k] != 0) && (m_prot >= m_thr[k]);
                clr = wr_en && wr_addr == 4 && wr_data[29+k];
                m_stat[k] = (hit || (m_stat[k] != 0 && !clr)) ? 1 : 0;
            end
            if (wr_en) begin
                if (wr_addr == 0) begin
                    m_strat = int'(wr_data[17:16]);
                    m_sel   = int'(wr_data[19:18]);
                end else if (wr_addr >= 1 && wr_addr <= 3)
                    m_thr[wr_addr-1] = int'(wr_data[14:0]);
            end
            m_prot = np;
        end
    endtask

    task automatic compare(string ptag, string ftag);
        logic [NG-1:0] ef;
        for (int k = 0; k < NG; k++) ef[k] = m_stat[k][0];
        n_checks++;
        if (int'(prot) != m_prot) begin
            n_fails++;
            $display("FAIL %s prot_temp actual=%0d expected=%0d", ptag, prot, m_prot);
        end
        n_checks++;
        if (flags !== ef) begin
            n_fails++;
            $display("FAIL %s stage_flag actual=%b expected=%b", ftag, flags, ef);
        end
        n_checks++;
        if (sdn !== ef[NG-1]) begin
            n_fails++;
            $display("FAIL R9 shutdown actual=%b expected=%b", sdn, ef[NG-1]);
        end
        n_checks++;
        if (rd_data !== ref_rd()) begin
            n_fails++;
            $display("FAIL R10 rd_data addr=%0d actual=%h expected=%h", rd_addr, rd_data, ref_rd());
        end
    endtask

    // advance one clock and compare all outputs with the model
    task automatic step(string ptag, string ftag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(ptag, ftag);
    endtask

    task automatic wr(int a, logic [31:0] d, string tag);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        step(tag, tag);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic set_sns(int a, int b, int c, int d);
        s[0] = TW'(a); s[1] = TW'(b); s[2] = TW'(c); s[3] = TW'(d);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        set_sns(0, 0, 0, 0);
        @(negedge clk);
        // R1: reset state on outputs and every register
        repeat (2) step("R1", "R1");
        set_sns(1000, 2000, 3000, 4000);
        for (int a = 0; a < 6; a++) begin rd_addr = AW'(a); step("R1", "R1"); end
        rst_n = 1'b1;

        // R2: mean mode, floor division and full-scale without wrap (limits still 0, R7)
        rd_addr = 3'd0;
        set_sns(100, 200, 300, 401); step("R2", "R7"); step("R2", "R7");
        set_sns(32767, 32767, 32767, 32767); step("R2", "R7"); step("R2", "R7");
        set_sns(1, 2, 0, 0); step("R2", "R7"); step("R2", "R7");

        // R3: hottest mode, the maximum in each position
        wr(0, 32'h0001_0000, "R3");
        for (int p = 0; p < NS; p++) begin
            set_sns(10, 20, 30, 40);
            s[p] = TW'(5000 + p);
            step("R3", "R7"); step("R3", "R7");
        end

        // R4: pick mode, every index
        for (int i = 0; i < NS; i++) begin
            wr(0, 32'h0002_0000 | (32'(i) << 18), "R4");
            set_sns(111, 222, 333, 444); step("R4", "R7"); step("R4", "R7");
        end

        // R5: reserved code acts as hottest
        wr(0, 32'h0003_0000, "R5");
        set_sns(7, 900, 8, 9); step("R5", "R7"); step("R5", "R7");

        // R10: program limits and read them back
        wr(1, 32'hFFFF_03E8, "R10");
        wr(2, 32'h0000_07D0, "R10");
        wr(3, 32'h0000_0BB8, "R10");
        for (int a = 0; a < 8; a++) begin rd_addr = AW'(a); step("R10", "R10"); end
        rd_addr = 3'd4;

        // R6: approach and cross each limit in hottest mode
        wr(0, 32'h0001_0000, "R6");
        set_sns(999, 0, 0, 0);  step("R6", "R6"); step("R6", "R6");
        set_sns(1000, 0, 0, 0); step("R6", "R6"); step("R6", "R6");
        set_sns(2500, 0, 0, 0); step("R6", "R6"); step("R6", "R6");
        set_sns(500, 0, 0, 0);  step("R6", "R6"); step("R6", "R6");

        // R8: clears, zero write, and set winning over clear
        wr(4, 32'h0000_0000, "R8"); step("R8", "R8");
        wr(4, 32'h2000_0000, "R8"); step("R8", "R8");
        set_sns(1500, 0, 0, 0); step("R8", "R8");
        wr(4, 32'h2000_0000, "R8"); step("R8", "R8");

        // R9: shutdown at stage 3, then released by clear
        set_sns(3000, 0, 0, 0); step("R9", "R9"); step("R9", "R9"); step("R9", "R9");
        set_sns(0, 0, 0, 0); step("R9", "R9");
        wr(4, 32'hE000_0000, "R9"); step("R9", "R9");

        // R7: zero a limit under high readings
        wr(3, 32'h0, "R7");
        set_sns(32767, 0, 0, 0); step("R7", "R7"); step("R7", "R7");
        wr(4, 32'h8000_0000, "R7"); step("R7", "R7"); step("R7", "R7");

        // mixed pseudo-random traffic
        for (int c = 0; c < 600; c++) begin
            for (int i = 0; i < NS; i++) s[i] = TW'($urandom_range(0, 32767));
            rd_addr = AW'($urandom_range(0, 7));
            if (c % 7 == 0)
                wr(0, {12'h0, 4'($urandom_range(0, 15)), 16'h0}, "R4");
            else if (c % 11 == 0)
                wr($urandom_range(1, 3), 32'($urandom_range(0, 32767)) & 32'h7FFF, "R6");
            else if (c % 5 == 0)
                wr(4, {3'($urandom_range(0, 7)), 29'h0}, "R8");
            else
                step("R2/R3/R4/R5", "R6/R8");
        end

        done = 1;
        summary();
        $finish;
    end
endmodule